// File: doc/BRIEF.md
# Permission-Checked Crossbar Arbiter

This block links six requesting masters to nine target ports. Each master drives a request with an address, a write flag, write data and a transfer size. It holds that request until it sees ready. Each target port carries its own round-robin arbiter. The arbiter picks one requesting master, forwards that master's request fields to the port, and returns the port's ready and read data to that master only. Masters that lose arbitration see ready held low.

Every address is first decoded to a region. The region and the requesting master then select a target port. Flash has three ports, and each flash-capable master has its own, so flash traffic never contends inside the crossbar. A fixed, asymmetric permission matrix limits which targets each master may reach. An address that decodes nowhere, or a target outside the master's permitted set, never reaches a port. The master instead receives ready and error in the same cycle.

Masters are indexed 0 to 5: core-1 instruction, core-1 data, core-1 system, core-2 system, DMA and radio. Targets are indexed 0 to 8: flash ports A, B and C, SRAM1, SRAM2, AHB1, AHB2, AHB4 and AHB5.

Top module: `xbar_arb`

## Requirements
- R1: Decode ranges are as follows. 0x0800_0000–0x0804_FFFF is flash. 0x2000_0000–0x2000_2FFF goes to SRAM1 (target 3). 0x2003_0000–0x2003_8FFF goes to SRAM2 (target 4). 0x4000_0000–0x47FF_FFFF goes to AHB1 (target 5). 0x4800_0000–0x57FF_FFFF goes to AHB2 (target 6). 0x5800_0000–0x5FFF_FFFF goes to AHB4 (target 7). Every address from 0x6000_0000 upward goes to AHB5 (target 8). Any other address is unmapped.
- R2: The permission sets are fixed per master. Masters 0 and 1 may reach flash, SRAM1 and SRAM2. Masters 2 and 4 may reach SRAM1, SRAM2, AHB1, AHB2 and AHB4. Master 3 may reach every region. Master 5 may reach only SRAM2.
- R3: An unmapped or unpermitted request raises ready and error in the same cycle as valid. No target port is asserted for it.
- R4: A granted request appears on its target port with the master's address, write flag, write data and size. The master's ready and read data follow that port's ready and read data, and its error stays low.
- R5: The arbiter of a target grants the first requester at or after its pointer. When a transfer completes, the pointer moves to the master after the granted one, wrapping from 5 to 0.
- R6: While a target port's ready is low, its grant does not change, even when other masters start requesting.
- R7: A master that is not granted sees ready low.
- R8: Flash requests from masters 0, 1 and 3 go to flash ports 0, 1 and 2. They can all be served in the same cycle.
- R9: After reset every pointer is 0 and no grant is held. With no valid request, no target port is asserted and every master's ready and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | NM | Request valid per master |
| m_addr | input | NM*32 | Request address per master |
| m_write | input | NM | Write flag per master |
| m_wdata | input | NM*DW | Write data per master |
| m_size | input | NM*2 | Transfer size per master |
| m_ready | output | NM | Transfer done (or refused) per master |
| m_rdata | output | NM*DW | Read data per master |
| m_err | output | NM | Refused request flag per master |
| t_valid | output | NT | Request valid per target port |
| t_addr | output | NT*32 | Forwarded address per target port |
| t_write | output | NT | Forwarded write flag per target port |
| t_wdata | output | NT*DW | Forwarded write data per target port |
| t_size | output | NT*2 | Forwarded size per target port |
| t_ready | input | NT | Target completes transfer |
| t_rdata | input | NT*DW | Read data per target port |

## Verification
The grant-hold and rotation properties assume one input rule: a master that has raised valid keeps valid and its request fields steady until it sees ready. The stimulus follows that rule everywhere. Each request is held from one falling edge until the rising edge where ready is seen. Masters in the contention phases re-issue only after their own completion. Reset is applied with every valid low, so no property sees a transfer in flight across reset.

// File: rtl/xbar_arb.sv
module xbar_arb #(
  parameter int NM = 6,
  parameter int NT = 9,
  parameter int DW = 32,
  parameter logic [NM*NT-1:0] PERMIT = {9'h010, 9'h0F8, 9'h1FC, 9'h0F8, 9'h01A, 9'h019},
  parameter logic [NM*4-1:0] FLASH_PORT = {4'd0, 4'd0, 4'd2, 4'd0, 4'd1, 4'd0}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_valid,
  input  logic [NM*32-1:0] m_addr,
  input  logic [NM-1:0]    m_write,
  input  logic [NM*DW-1:0] m_wdata,
  input  logic [NM*2-1:0]  m_size,
  output logic [NM-1:0]    m_ready,
  output logic [NM*DW-1:0] m_rdata,
  output logic [NM-1:0]    m_err,
  output logic [NT-1:0]    t_valid,
  output logic [NT*32-1:0] t_addr,
  output logic [NT-1:0]    t_write,
  output logic [NT*DW-1:0] t_wdata,
  output logic [NT*2-1:0]  t_size,
  input  logic [NT-1:0]    t_ready,
  input  logic [NT*DW-1:0] t_rdata
);
  localparam int MW = $clog2(NM);
  localparam int TW = $clog2(NT + 1);
  localparam logic [TW-1:0] NONE = TW'(NT);

  function automatic logic [TW-1:0] decode(input logic [31:0] a, input int m);
    if (a >= 32'h0800_0000 && a <= 32'h0804_FFFF) return TW'(FLASH_PORT[m*4 +: 4]);
    if (a >= 32'h2000_0000 && a <= 32'h2000_2FFF) return TW'(3);
    if (a >= 32'h2003_0000 && a <= 32'h2003_8FFF) return TW'(4);
    if (a >= 32'h4000_0000 && a <= 32'h47FF_FFFF) return TW'(5);
    if (a >= 32'h4800_0000 && a <= 32'h57FF_FFFF) return TW'(6);
    if (a >= 32'h5800_0000 && a <= 32'h5FFF_FFFF) return TW'(7);
    if (a >= 32'h6000_0000) return TW'(8);
    return NONE;
  endfunction

  logic [TW-1:0] tsel [NM];
  logic [NM-1:0] deny;
  logic [NM-1:0] req  [NT];
  logic [MW-1:0] ptr  [NT];
  logic [MW-1:0] own  [NT];
  logic [MW-1:0] gsel [NT];
  logic [NT-1:0] busy;

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      tsel[m] = decode(m_addr[m*32 +: 32], m);
      deny[m] = m_valid[m];
      for (int t = 0; t < NT; t++)
        if (tsel[m] == TW'(t) && PERMIT[m*NT + t]) deny[m] = 1'b0;
    end
    for (int t = 0; t < NT; t++)
      for (int m = 0; m < NM; m++)
        req[t][m] = m_valid[m] && tsel[m] == TW'(t) && PERMIT[m*NT + t];
  end

  always_comb begin
    logic [MW-1:0] pick;
    logic fnd;
    for (int t = 0; t < NT; t++) begin
      pick = ptr[t];
      fnd = 1'b0;
      for (int k = 0; k < NM; k++) begin
        int i;
        i = (int'(ptr[t]) + k) % NM;
        if (!fnd && req[t][i]) begin
          pick = MW'(i);
          fnd = 1'b1;
        end
      end
      gsel[t] = busy[t] ? own[t] : pick;
      t_valid[t] = busy[t] | fnd;
      t_addr[t*32 +: 32] = m_addr[int'(gsel[t])*32 +: 32];
      t_wdata[t*DW +: DW] = m_wdata[int'(gsel[t])*DW +: DW];
      t_size[t*2 +: 2] = m_size[int'(gsel[t])*2 +: 2];
      t_write[t] = m_write[gsel[t]];
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (!rst_n) begin
        ptr[t] <= '0;
        own[t] <= '0;
        busy[t] <= 1'b0;
      end else if (t_valid[t] && t_ready[t]) begin
        busy[t] <= 1'b0;
        ptr[t] <= (gsel[t] == MW'(NM - 1)) ? '0 : gsel[t] + 1'b1;
      end else if (t_valid[t]) begin
        busy[t] <= 1'b1;
        own[t] <= gsel[t];
      end
    end
  end

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      m_err[m] = deny[m];
      m_ready[m] = deny[m];
      m_rdata[m*DW +: DW] = '0;
      if (m_valid[m] && !deny[m]) begin
        for (int t = 0; t < NT; t++) begin
          if (tsel[m] == TW'(t) && t_valid[t] && gsel[t] == MW'(m)) begin
            m_ready[m] = t_ready[t];
            m_rdata[m*DW +: DW] = t_rdata[t*DW +: DW];
          end
        end
      end
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_chk
    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid[t] && !t_ready[t] |=> t_valid[t] && gsel[t] == $past(gsel[t]));
    // R5
    rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid[t] && t_ready[t] |=> !($countones(req[t]) > 1) || gsel[t] != $past(gsel[t]));
    // R2
    permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid[t] |-> PERMIT[int'(gsel[t])*NT + t]);
    // R3
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid[t] |-> !m_err[gsel[t]]);
  end
endmodule

// File: tb/xbar_arb_bench.sv
module xbar_arb_bench;
  localparam int NM = 6, NT = 9, DW = 32;
  logic clk = 0, rst_n = 0;
  logic [NM-1:0] mv = '0, mw = '0;
  logic [NM*32-1:0] ma = '0;
  logic [NM*DW-1:0] md = '0;
  logic [NM*2-1:0] ms = '0;
  logic [NM-1:0] m_ready, m_err;
  logic [NM*DW-1:0] m_rdata;
  logic [NT-1:0] t_valid, t_write, tr = '1;
  logic [NT*32-1:0] t_addr;
  logic [NT*DW-1:0] t_wdata, t_rdata;
  logic [NT*2-1:0] t_size;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] rpat(int t);
    return 32'h5A00_0000 + t * 32'h111;
  endfunction
  for (genvar t = 0; t < NT; t++) begin : g_rd
    assign t_rdata[t*DW +: DW] = rpat(t);
  end

  xbar_arb u_xbar_arb (.clk, .rst_n, .m_valid(mv), .m_addr(ma), .m_write(mw), .m_wdata(md),
    .m_size(ms), .m_ready, .m_rdata, .m_err, .t_valid, .t_addr, .t_write, .t_wdata,
    .t_size, .t_ready(tr), .t_rdata);

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic int etgt(int m, logic [31:0] a);
    int rg, tg;
    logic [6:0] allow;
    rg = -1;
    if (a >= 32'h0800_0000 && a <= 32'h0804_FFFF) rg = 0;
    else if (a >= 32'h2000_0000 && a <= 32'h2000_2FFF) rg = 1;
    else if (a >= 32'h2003_0000 && a <= 32'h2003_8FFF) rg = 2;
    else if (a >= 32'h4000_0000 && a <= 32'h47FF_FFFF) rg = 3;
    else if (a >= 32'h4800_0000 && a <= 32'h57FF_FFFF) rg = 4;
    else if (a >= 32'h5800_0000 && a <= 32'h5FFF_FFFF) rg = 5;
    else if (a >= 32'h6000_0000) rg = 6;
    if (rg < 0) return 9;
    case (m)
      0, 1: allow = 7'b0000111;
      2, 4: allow = 7'b0111110;
      3: allow = 7'b1111111;
      default: allow = 7'b0000100;
    endcase
    if (!allow[rg]) return 9;
    if (rg == 0) tg = (m == 0) ? 0 : (m == 1) ? 1 : 2;
    else tg = rg + 2;
    return tg;
  endfunction

  function automatic logic [31:0] sw_addr(int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0800_0000;  2: return 32'h0804_FFFC;
      3: return 32'h0805_0000;  4: return 32'h1FFF_FFFC;  5: return 32'h2000_0000;
      6: return 32'h2000_2FFC;  7: return 32'h2000_3000;  8: return 32'h2003_0000;
      9: return 32'h2003_8FFC; 10: return 32'h2003_9000; 11: return 32'h3FFF_FFFC;
      12: return 32'h4000_0000; 13: return 32'h47FF_FFFC; 14: return 32'h4800_0000;
      15: return 32'h57FF_FFFC; 16: return 32'h5800_0000; 17: return 32'h5FFF_FFFC;
      18: return 32'h6000_0000; default: return 32'hFFFF_FFFC;
    endcase
  endfunction

  task automatic set_m(int m, logic [31:0] a, logic w, logic [1:0] s);
    mv[m] = 1'b1; ma[m*32 +: 32] = a; mw[m] = w;
    md[m*DW +: DW] = a ^ 32'hFFFF_0000; ms[m*2 +: 2] = s;
  endtask

  task automatic do_reset();
    mv = '0; rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  function automatic int rr_pick(int p, logic [NM-1:0] mask);
    for (int k = 0; k < NM; k++) if (mask[(p + k) % NM]) return (p + k) % NM;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p;
    do_reset();
    #2;
    // R9 reset state
    chk(t_valid == 0, "R9 t_valid", t_valid, 0);
    chk(m_ready == 0 && m_err == 0, "R9 ready/err", {m_ready, m_err}, 0);

    // R1 R2 R3 R4 sweep over masters and range edges
    for (int m = 0; m < NM; m++) begin
      for (int i = 0; i < 20; i++) begin
        int e;
        logic [31:0] a;
        a = sw_addr(i);
        e = etgt(m, a);
        @(negedge clk);
        mv = '0;
        set_m(m, a, 1'((m + i) % 2), 2'((i % 3)));
        #2;
        if (e == 9) begin
          chk(m_ready == (6'b1 << m) && m_err == (6'b1 << m), "R2 R3 refuse", {m_ready, m_err}, {6'b1 << m, 6'b1 << m});
          chk(t_valid == 0, "R3 no target", t_valid, 0);
        end else begin
          chk(t_valid == (9'b1 << e), "R1 decode", t_valid, 9'b1 << e);
          chk(t_addr[e*32 +: 32] == a && t_wdata[e*DW +: DW] == (a ^ 32'hFFFF_0000)
              && t_write[e] == 1'((m + i) % 2) && t_size[e*2 +: 2] == 2'(i % 3),
              "R4 forward", t_addr[e*32 +: 32], a);
          chk(m_ready == (6'b1 << m) && m_err == 0 && m_rdata[m*DW +: DW] == rpat(e),
              "R4 response", m_rdata[m*DW +: DW], rpat(e));
        end
        @(posedge clk);
      end
    end
    @(negedge clk); mv = '0;

    // R8 parallel flash ports
    set_m(0, 32'h0800_0100, 0, 2); set_m(1, 32'h0800_0200, 0, 2); set_m(3, 32'h0800_0300, 1, 2);
    #2;
    chk(t_valid == 9'b000000111, "R8 flash ports", t_valid, 9'b111);
    chk(t_addr[2*32 +: 32] == 32'h0800_0300 && m_rdata[3*DW +: DW] == rpat(2), "R8 core-2 port",
        t_addr[2*32 +: 32], 32'h0800_0300);
    chk(m_ready == 6'b001011, "R8 all served", m_ready, 6'b001011);
    @(posedge clk);

    // R5 R7 round robin, all masters on SRAM2
    do_reset();
    for (int m = 0; m < NM; m++) set_m(m, 32'h2003_0000 + m * 4, 0, 2);
    p = 0;
    for (int c = 0; c < 12; c++) begin
      int w;
      w = rr_pick(p, mv);
      #2;
      chk(m_ready == (6'b1 << w), "R5 R7 rr all", m_ready, 6'b1 << w);
      @(posedge clk); p = (w + 1) % NM;
      @(negedge clk);
    end
    mv = 6'b101010;
    for (int c = 0; c < 8; c++) begin
      int w;
      w = rr_pick(p, mv);
      #2;
      chk(m_ready == (6'b1 << w), "R5 rr subset", m_ready, 6'b1 << w);
      @(posedge clk); p = (w + 1) % NM;
      @(negedge clk);
    end

    // R6 R7 grant hold on AHB1 with stalled target
    do_reset();
    tr = '1; tr[5] = 1'b0;
    set_m(4, 32'h4000_0000, 1, 2);
    #2;
    chk(t_valid[5] && m_ready == 0, "R6 stall start", {t_valid[5], m_ready}, 7'h40);
    @(negedge clk);
    set_m(2, 32'h4000_0010, 0, 2);
    for (int c = 0; c < 3; c++) begin
      #2;
      chk(t_addr[5*32 +: 32] == 32'h4000_0000, "R6 hold", t_addr[5*32 +: 32], 32'h4000_0000);
      chk(m_ready == 0, "R7 loser low", m_ready, 0);
      @(negedge clk);
    end
    tr[5] = 1'b1;
    #2;
    chk(m_ready == 6'b010000, "R6 complete", m_ready, 6'b010000);
    @(negedge clk);
    mv[4] = 1'b0;
    #2;
    chk(t_addr[5*32 +: 32] == 32'h4000_0010 && m_ready == 6'b000100, "R5 wrap", m_ready, 6'b000100);
    @(negedge clk); mv = '0;
    #2;
    chk(t_valid == 0 && m_ready == 0, "R9 idle", {t_valid, m_ready}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule